// File: doc/BRIEF.md
# Countdown Timer Bank

A bus-mapped peripheral with three reloadable down-counting channels and one free-running up-counter. Channels 0 and 1 are 16 bits wide by default and channel 2 is 32 bits wide. Each channel has a load word, a read-only value word, a control word and an acknowledge word. It decrements on a tick strobe from one of two sources. When it passes zero it either reloads or wraps, and it raises a sticky interrupt. The up-counter is 40 bits wide and advances on its own tick strobe. A bit in its upper word enables it, and it has no interrupt path.

Software sets up a channel in three writes: first the control word with the run bit clear, then the load word, then the control word with the run bit set. It acknowledges an interrupt by writing any value to the channel's acknowledge word. The up-counter is read as a low word holding bits 31:0 and an upper word holding the remaining bits and the enable bit.

Top module: `timer_bank`

## Requirements
- R1: After reset every readable word is zero and `irq` is all zero.
- R2: Word map (word addresses): channel n (n = 0..2) has load at 4n, value at 4n+1, control at 4n+2 and acknowledge at 4n+3. Control bit 7 is run and bit 6 is reload mode. A running channel decrements its value by one on each selected tick. On a selected tick at value zero, a channel in reload mode copies its load word into its value and sets its interrupt, so the period is load+1 ticks. The control word reads back with bits 7, 6 and 3 in place.
- R3: Control bit 3 set selects `tick_fast` as the channel's tick, and clear selects `tick_slow`. The strobe that is not selected has no effect on the value.
- R4: With bit 6 clear, a selected tick at value zero wraps the value to all ones of the channel's width and sets its interrupt.
- R5: While run is clear, ticks leave the value unchanged, and a write to the load word also sets the value to the written data.
- R6: While run is set, a write to the load word leaves the value unchanged. The new load is used at the next underflow.
- R7: The interrupt stays set until any write to the channel's acknowledge word, which clears it on the next cycle.
- R8: If an underflow and an acknowledge write occur in the same cycle, the interrupt stays set.
- R9: The up-counter has its low word at word 12 (bits 31:0) and its upper word at word 13 (enable at bit 8, counter bits 39:32 at bits 7:0). It increments once per `tick_free` only while enabled. The channel tick strobes do not affect it.
- R10: Writing the enable bit as 1 while the up-counter is disabled zeroes it. Writing 1 while it is already enabled does not.
- R11: Up-counter activity never changes `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for `bus_addr` |
| bus_addr | input | ADDR_W | Word address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| tick_slow | input | 1 | Slow tick enable strobe |
| tick_fast | input | 1 | Fast tick enable strobe |
| tick_free | input | 1 | Tick enable strobe for the up-counter |
| irq | output | 3 | Per-channel sticky interrupt |

## Verification
The bench uses the default parameters: channel widths 16, 16 and 32, a 40-bit up-counter and a 4-bit word address. With a 16-bit channel, the wrap to 0xFFFF in free mode shows up within a couple of ticks. Loading the 32-bit channel with zero exposes its full-width wrap on a single tick. Carry into the up-counter's upper byte would take 2^32 ticks and is out of reach, so the upper word is checked only for its enable bit and zero high bits.

// File: rtl/timer_bank_pkg.sv
package timer_bank_pkg;
   localparam int NCH      = 3;
   localparam int DW       = 32;
   localparam int CTL_RUN  = 7;
   localparam int CTL_PER  = 6;
   localparam int CTL_FAST = 3;
   localparam int HI_EN    = 8;
   localparam int FREE_LO_WORD = 12;
   localparam int FREE_HI_WORD = 13;

   typedef enum logic [1:0] {
      SLOT_LOAD  = 2'd0,
      SLOT_VALUE = 2'd1,
      SLOT_CTRL  = 2'd2,
      SLOT_ACK   = 2'd3
   } slot_e;

   typedef struct packed {
      logic run;
      logic per;
      logic fast;
   } chan_cfg_t;
endpackage

// File: rtl/timer_bank_chan.sv
module timer_bank_chan
   import timer_bank_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld_we,
   input  logic         ctrl_we,
   input  logic         ack_we,
   input  logic [W-1:0] ld_data,
   input  chan_cfg_t    cfg_in,
   input  logic         tick_slow,
   input  logic         tick_fast,
   output logic [W-1:0] value,
   output logic [W-1:0] load_q,
   output chan_cfg_t    cfg,
   output logic         irq,
   output logic         uflow
);
   logic tick;

   assign tick  = cfg.fast ? tick_fast : tick_slow;
   assign uflow = cfg.run && tick && (value == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         value  <= '0;
         load_q <= '0;
         cfg    <= '0;
         irq    <= 1'b0;
      end else begin
         if (ctrl_we) cfg <= cfg_in;
         if (ld_we) load_q <= ld_data;
         if (cfg.run && tick) begin
            if (value == '0) value <= cfg.per ? load_q : '1;
            else             value <= value - 1'b1;
         end else if (ld_we && !cfg.run) begin
            value <= ld_data;
         end
         if (uflow)       irq <= 1'b1;
         else if (ack_we) irq <= 1'b0;
      end
   end
endmodule

// File: rtl/timer_bank_free.sv
module timer_bank_free #(
   parameter int W = 40
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         hi_we,
   input  logic         en_in,
   input  logic         tick,
   output logic [W-1:0] cnt,
   output logic         en
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         en  <= 1'b0;
      end else begin
         if (hi_we) en <= en_in;
         if (hi_we && en_in && !en) cnt <= '0;
         else if (en && tick)       cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/timer_bank.sv
module timer_bank
   import timer_bank_pkg::*;
#(
   parameter int ADDR_W     = 4,
   parameter int CH_W [NCH] = '{16, 16, 32},
   parameter int FREE_W     = 40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DW-1:0]     bus_wdata,
   output logic [DW-1:0]     bus_rdata,
   input  logic              tick_slow,
   input  logic              tick_fast,
   input  logic              tick_free,
   output logic [NCH-1:0]    irq
);
   localparam int HI_BITS = FREE_W - DW;

   if (ADDR_W < 4) begin : g_bad_addr
      $error("timer_bank: ADDR_W must be at least 4");
   end
   if (HI_BITS < 1 || HI_BITS > HI_EN) begin : g_bad_free
      $error("timer_bank: FREE_W must lie in 33..40");
   end

   chan_cfg_t        cfg_in;
   logic [NCH-1:0]   uflow;
   logic [DW-1:0]    rd_load [NCH];
   logic [DW-1:0]    rd_val  [NCH];
   logic [DW-1:0]    rd_ctrl [NCH];
   logic [FREE_W-1:0] free_cnt;
   logic             free_en;
   logic             free_hi_we;
   logic [DW-1:0]    rd_hi;

   assign cfg_in = '{run: bus_wdata[CTL_RUN], per: bus_wdata[CTL_PER],
                     fast: bus_wdata[CTL_FAST]};

   for (genvar g = 0; g < NCH; g++) begin : g_ch
      localparam int W = CH_W[g];
      localparam logic [ADDR_W-1:0] A_LD   = ADDR_W'(4*g + int'(SLOT_LOAD));
      localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(4*g + int'(SLOT_CTRL));
      localparam logic [ADDR_W-1:0] A_ACK  = ADDR_W'(4*g + int'(SLOT_ACK));

      if (W < 2 || W > DW) begin : g_bad_w
         $error("timer_bank: channel width out of range");
      end

      logic [W-1:0] value, load_q;
      chan_cfg_t    cfg;

      timer_bank_chan #(.W(W)) u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .ld_we     (bus_wr && bus_addr == A_LD),
         .ctrl_we   (bus_wr && bus_addr == A_CTRL),
         .ack_we    (bus_wr && bus_addr == A_ACK),
         .ld_data   (bus_wdata[W-1:0]),
         .cfg_in    (cfg_in),
         .tick_slow (tick_slow),
         .tick_fast (tick_fast),
         .value     (value),
         .load_q    (load_q),
         .cfg       (cfg),
         .irq       (irq[g]),
         .uflow     (uflow[g])
      );

      assign rd_load[g] = DW'(load_q);
      assign rd_val[g]  = DW'(value);
      always_comb begin
         rd_ctrl[g]           = '0;
         rd_ctrl[g][CTL_RUN]  = cfg.run;
         rd_ctrl[g][CTL_PER]  = cfg.per;
         rd_ctrl[g][CTL_FAST] = cfg.fast;
      end
   end

   assign free_hi_we = bus_wr && bus_addr == ADDR_W'(FREE_HI_WORD);

   timer_bank_free #(.W(FREE_W)) u_free (
      .clk   (clk),
      .rst_n (rst_n),
      .hi_we (free_hi_we),
      .en_in (bus_wdata[HI_EN]),
      .tick  (tick_free),
      .cnt   (free_cnt),
      .en    (free_en)
   );

   always_comb begin
      rd_hi                = '0;
      rd_hi[HI_BITS-1:0]   = free_cnt[FREE_W-1:DW];
      rd_hi[HI_EN]         = free_en;
   end

   always_comb begin
      bus_rdata = '0;
      for (int c = 0; c < NCH; c++) begin
         if (bus_addr == ADDR_W'(4*c + int'(SLOT_LOAD)))  bus_rdata = rd_load[c];
         if (bus_addr == ADDR_W'(4*c + int'(SLOT_VALUE))) bus_rdata = rd_val[c];
         if (bus_addr == ADDR_W'(4*c + int'(SLOT_CTRL)))  bus_rdata = rd_ctrl[c];
      end
      if (bus_addr == ADDR_W'(FREE_LO_WORD)) bus_rdata = free_cnt[DW-1:0];
      if (bus_addr == ADDR_W'(FREE_HI_WORD)) bus_rdata = rd_hi;
   end
endmodule

// File: rtl/timer_bank_chk.sv
module timer_bank_chk #(
   parameter int ADDR_W = 4,
   parameter int NCH    = 3,
   parameter int FREE_W = 40
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              hi_en_bit,
   input logic [NCH-1:0]    irq,
   input logic [NCH-1:0]    uflow,
   input logic [FREE_W-1:0] free_cnt,
   input logic              free_en
);
   logic hi_wr;
   assign hi_wr = bus_wr && bus_addr == ADDR_W'(13);

   for (genvar g = 0; g < NCH; g++) begin : g_chk
      logic ack_wr;
      assign ack_wr = bus_wr && bus_addr == ADDR_W'(4*g + 3);

      AST_UFLOW_SETS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
         uflow[g] |=> irq[g]);                                   // R8
      AST_ACK_CLEARS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
         ack_wr && !uflow[g] |=> !irq[g]);                       // R7
      AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         irq[g] && !ack_wr |=> irq[g]);                          // R7
      AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(irq[g]) |-> $past(uflow[g]));                     // R2
   end

   AST_FREE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !free_en && !hi_wr |=> $stable(free_cnt));                 // R9
   AST_FREE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      hi_wr && hi_en_bit && !free_en |=> free_cnt == '0);        // R10
endmodule

bind timer_bank timer_bank_chk #(
   .ADDR_W (ADDR_W),
   .NCH    (timer_bank_pkg::NCH),
   .FREE_W (FREE_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .hi_en_bit (bus_wdata[8]),
   .irq       (irq),
   .uflow     (uflow),
   .free_cnt  (free_cnt),
   .free_en   (free_en)
);

// File: tb/timer_bank_test.sv
module timer_bank_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        tick_slow = 1'b0, tick_fast = 1'b0, tick_free = 1'b0;
   logic [2:0]  irq;
   int          checks = 0;
   int          failures = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   timer_bank uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_slow(tick_slow),
      .tick_fast(tick_fast), .tick_free(tick_free), .irq(irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      bus_addr = 4'(a);
      #1;
      d = bus_rdata;
   endtask

   // kind: 0 slow, 1 fast, 2 free
   task automatic tick(input int kind, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         tick_slow = (kind == 0); tick_fast = (kind == 1); tick_free = (kind == 2);
         @(negedge clk);
         tick_slow = 1'b0; tick_fast = 1'b0; tick_free = 1'b0;
      end
   endtask

   task automatic t_reset;
      logic [31:0] d;
      logic [31:0] acc = '0;
      for (int a = 0; a < 14; a++) begin
         rd(a, d);
         acc |= d;
      end
      chk("R1 all words zero", acc, 32'h0);
      chk("R1 irq zero", 32'(irq), 32'h0);
   endtask

   task automatic t_periodic;
      logic [31:0] d;
      wr(2, 32'h40); wr(0, 3); wr(2, 32'hC0);
      rd(2, d); chk("R2 ctrl readback", d, 32'hC0);
      rd(1, d); chk("R2 value after setup", d, 3);
      tick(0, 3);
      rd(1, d); chk("R2 counted to zero", d, 0);
      chk("R2 no irq before underflow", 32'(irq[0]), 0);
      tick(0, 1);
      rd(1, d); chk("R2 reload on underflow", d, 3);
      chk("R2 irq on underflow", 32'(irq[0]), 1);
      chk("R2 other channels quiet", 32'(irq[2:1]), 0);
   endtask

   task automatic t_ack;
      logic [31:0] d;
      tick(0, 1);
      chk("R7 irq sticky", 32'(irq[0]), 1);
      wr(3, 32'h0);
      chk("R7 ack clears irq", 32'(irq[0]), 0);
      rd(1, d); chk("R7 value after ack", d, 2);
   endtask

   task automatic t_race;
      logic [31:0] d;
      tick(0, 2);
      @(negedge clk);
      tick_slow = 1'b1; bus_wr = 1'b1; bus_addr = 4'd3; bus_wdata = '0;
      @(negedge clk);
      tick_slow = 1'b0; bus_wr = 1'b0;
      chk("R8 underflow beats ack", 32'(irq[0]), 1);
      rd(1, d); chk("R8 reload during race", d, 3);
      wr(3, 32'h0);
      chk("R8 later ack clears", 32'(irq[0]), 0);
   endtask

   task automatic t_fast_and_disabled;
      logic [31:0] d;
      wr(2, 32'h40);
      wr(6, 32'h48); wr(4, 2); wr(6, 32'hC8);
      tick(0, 3);
      rd(5, d); chk("R3 slow ignored by fast channel", d, 2);
      rd(1, d); chk("R5 disabled channel holds", d, 3);
      tick(1, 1);
      rd(5, d); chk("R3 fast tick decrements", d, 1);
      rd(1, d); chk("R3 fast ignored by slow channel", d, 3);
      wr(0, 9);
      rd(1, d); chk("R5 load copies when disabled", d, 9);
   endtask

   task automatic t_load_running;
      logic [31:0] d;
      wr(2, 32'hC0);
      wr(0, 2);
      rd(1, d); chk("R6 load leaves running value", d, 9);
      tick(0, 9);
      rd(1, d); chk("R6 count reaches zero", d, 0);
      tick(0, 1);
      rd(1, d); chk("R6 new load used at underflow", d, 2);
      wr(3, 32'h0);
   endtask

   task automatic t_wrap;
      logic [31:0] d;
      wr(2, 32'h00); wr(0, 1); wr(2, 32'h80);
      tick(0, 1);
      rd(1, d); chk("R4 counts down", d, 0);
      tick(0, 1);
      rd(1, d); chk("R4 16-bit wrap", d, 32'h0000FFFF);
      chk("R4 irq on wrap", 32'(irq[0]), 1);
      tick(0, 1);
      rd(1, d); chk("R4 continues after wrap", d, 32'h0000FFFE);
      wr(10, 32'h0); wr(8, 0); wr(10, 32'h80);
      tick(0, 1);
      rd(9, d); chk("R4 32-bit wrap", d, 32'hFFFFFFFF);
      chk("R4 irq on 32-bit wrap", 32'(irq[2]), 1);
      wr(3, 0); wr(11, 0);
      chk("R7 both acks", 32'(irq), 0);
   endtask

   task automatic t_free;
      logic [31:0] d;
      tick(2, 3);
      rd(12, d); chk("R9 disabled holds", d, 0);
      wr(13, 32'h100);
      rd(13, d); chk("R9 upper word readback", d, 32'h100);
      tick(2, 5);
      rd(12, d); chk("R9 counts free ticks", d, 5);
      chk("R11 no irq from up-counter", 32'(irq), 0);
      wr(13, 32'h0);
      tick(2, 2);
      rd(12, d); chk("R9 stops when disabled", d, 5);
      wr(13, 32'h100);
      rd(12, d); chk("R10 enable zeroes", d, 0);
      tick(2, 3);
      wr(13, 32'h100);
      rd(12, d); chk("R10 re-enable keeps count", d, 3);
      tick(0, 1); tick(1, 1);
      rd(12, d); chk("R9 channel ticks ignored", d, 3);
      rd(13, d); chk("R9 upper word high bits", d, 32'h100);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_periodic();
      t_ack();
      t_race();
      t_fast_and_disabled();
      t_load_running();
      t_wrap();
      t_free();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule